// File: doc/BRIEF.md
# Key-protected independent watchdog timer

The block is a watchdog with four bus-addressable registers: a key register, a prescaler register, a reload register and a status register. A down counter is clocked by a power-of-two divider. When the counter has run through zero, the block emits a single-cycle reset pulse. It then reloads and keeps counting. Software must keep writing a refresh key to push the pulse further away.

Configuration writes are protected. The prescaler and reload registers accept data only while an unlock key is in force, and a lock key closes them again. Every accepted configuration write is held as a programmed value. It becomes the value the counting logic uses only after a fixed number of prescaled ticks. While that transfer is under way, a status flag stays raised. Once counting has begun, nothing except the block reset stops it.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, wd_rst is low, the status register reads 0, the prescaler register reads 0 and the reload register reads 0xFFF.
- R2: Register addresses are: key 0, prescaler 1, reload 2 and status 3. Writing 0x5555 to the key register unlocks the prescaler and reload registers, and reads of those registers then return the value written. The key register reads 0.
- R3: While locked (after reset, or after 0x0000 is written to the key register), writes to the prescaler and reload registers are ignored: the readback values and the status register are unchanged.
- R4: A prescaler code N selects a divide ratio of 2^(N+2). A written code above MAX_CODE (6 or 8, giving ratios up to 256 or 1024) is stored as MAX_CODE.
- R5: The reload register holds 12 bits. Write data bits above bit 11 are dropped.
- R6: Status bit 0 is set in the cycle after an accepted prescaler write. It stays set for SYNC_TICKS prescaled ticks and then clears, at which point the new code takes effect.
- R7: Status bit 1 behaves the same way for reload writes.
- R8: Writing 0xCCCC to the key register starts the watchdog. It loads the counter with the active reload value R and restarts the divider. The first wd_rst pulse goes high (R+1)*2^(N+2) cycles after the write.
- R9: wd_rst is high for exactly one cycle. The counter then reloads by itself, and pulses repeat every (R+1)*2^(N+2) cycles.
- R10: Writing 0xAAAA to the key register while running reloads the counter and restarts the divider. The next pulse then comes (R+1)*2^(N+2) cycles after that write.
- R11: Once started, the watchdog keeps running. Writing the lock key or any other key value does not stop it or shift its pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| wd_rst | output | 1 | Single-cycle watchdog reset pulse |

## Verification
The bench builds the block with MAX_CODE set to 8, a 12-bit reload and SYNC_TICKS set to 2. This brings the whole divide range from 4 to 1024 within a sweep. For every prescaler code, it measures both the first pulse and the following period across several reload values, including the largest reload at the smallest divide. The short synchronisation window keeps the status flags observable as they set and clear within a few dozen cycles. It also allows saturation of codes above 8, masking of reload bits, refresh timing and the no-stop behaviour to be checked against arithmetic cycle counts.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int BUS_W = 16;

    localparam logic [1:0] A_KEY    = 2'd0;
    localparam logic [1:0] A_PRESC  = 2'd1;
    localparam logic [1:0] A_RELOAD = 2'd2;
    localparam logic [1:0] A_STATUS = 2'd3;

    localparam logic [BUS_W-1:0] K_UNLOCK = 16'h5555;
    localparam logic [BUS_W-1:0] K_LOCK   = 16'h0000;
    localparam logic [BUS_W-1:0] K_START  = 16'hCCCC;
    localparam logic [BUS_W-1:0] K_KICK   = 16'hAAAA;
endpackage

// File: rtl/kwd_pend.sv
// Programmed/active register pair; the programmed value moves to the
// active copy after SYNC_TICKS prescaled ticks, with busy raised meanwhile.
module kwd_pend #(
    parameter int W = 12,
    parameter int SYNC_TICKS = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wval,
    input  logic         tick,
    output logic [W-1:0] prog,
    output logic [W-1:0] act,
    output logic         busy
);
    localparam int SW = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        logic [W-1:0]  prog;
        logic [W-1:0]  act;
        logic          busy;
        logic [SW-1:0] left;
    } pend_t;

    pend_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.prog = wval;
            s_d.busy = 1'b1;
            s_d.left = SW'(SYNC_TICKS);
        end else if (s_q.busy && tick) begin
            if (s_q.left <= SW'(1)) begin
                s_d.act  = s_q.prog;
                s_d.busy = 1'b0;
                s_d.left = '0;
            end else begin
                s_d.left = s_q.left - SW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{prog: RST_VAL, act: RST_VAL, busy: 1'b0, left: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign prog = s_q.prog;
    assign act  = s_q.act;
    assign busy = s_q.busy;
endmodule

// File: rtl/kwd_regs.sv
// Key decoding, write lock and the two synchronised configuration registers.
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int MAX_CODE = 6,
    parameter int RLD_W = 12,
    parameter int SYNC_TICKS = 2,
    localparam int PCODE_W = $clog2(MAX_CODE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic               tick,
    output logic               unlocked,
    output logic               start_req,
    output logic               kick_req,
    output logic [PCODE_W-1:0] prog_code,
    output logic [PCODE_W-1:0] act_code,
    output logic [RLD_W-1:0]   prog_reload,
    output logic [RLD_W-1:0]   act_reload,
    output logic               presc_busy,
    output logic               reload_busy
);
    typedef struct packed {
        logic unlocked;
    } lock_t;

    lock_t s_d, s_q;
    logic wr_key, pr_load, rl_load;
    logic [PCODE_W-1:0] code_in;

    always_comb begin
        s_d     = s_q;
        wr_key  = bus_wr && (bus_addr == A_KEY);
        pr_load = bus_wr && (bus_addr == A_PRESC) && s_q.unlocked;
        rl_load = bus_wr && (bus_addr == A_RELOAD) && s_q.unlocked;
        if (wr_key && bus_wdata == K_UNLOCK) begin
            s_d.unlocked = 1'b1;
        end else if (wr_key && bus_wdata == K_LOCK) begin
            s_d.unlocked = 1'b0;
        end
        if (bus_wdata > BUS_W'(MAX_CODE)) begin
            code_in = PCODE_W'(MAX_CODE);
        end else begin
            code_in = bus_wdata[PCODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{unlocked: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign unlocked  = s_q.unlocked;
    assign start_req = wr_key && (bus_wdata == K_START);
    assign kick_req  = wr_key && (bus_wdata == K_KICK);

    kwd_pend #(.W(PCODE_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_pend_presc (
        .clk(clk), .rst_n(rst_n), .load(pr_load), .wval(code_in), .tick(tick),
        .prog(prog_code), .act(act_code), .busy(presc_busy)
    );

    kwd_pend #(.W(RLD_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) u_pend_reload (
        .clk(clk), .rst_n(rst_n), .load(rl_load), .wval(bus_wdata[RLD_W-1:0]), .tick(tick),
        .prog(prog_reload), .act(act_reload), .busy(reload_busy)
    );
endmodule

// File: rtl/kwd_presc.sv
// Power-of-two divider: a tick every 2^(code+2) cycles, restartable.
module kwd_presc #(
    parameter int MAX_CODE = 6,
    localparam int PCODE_W = $clog2(MAX_CODE + 1),
    localparam int DW = MAX_CODE + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PCODE_W-1:0] code,
    input  logic               restart,
    output logic               tick
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } div_t;

    div_t s_d, s_q;
    logic [DW-1:0] mask;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < int'(code) + 2);
        end
        tick = &(s_q.cnt | ~mask);
        s_d  = s_q;
        if (restart || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/kwd_count.sv
// Down counter that pulses the reset output on a tick at zero, then reloads.
module kwd_count #(
    parameter int RLD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             kick_req,
    input  logic             tick,
    input  logic [RLD_W-1:0] reload,
    output logic             running,
    output logic             wd_rst
);
    typedef struct packed {
        logic             running;
        logic [RLD_W-1:0] cnt;
        logic             pulse;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pulse = 1'b0;
        if (start_req || (kick_req && s_q.running)) begin
            s_d.running = 1'b1;
            s_d.cnt     = reload;
        end else if (s_q.running && tick) begin
            if (s_q.cnt == '0) begin
                s_d.pulse = 1'b1;
                s_d.cnt   = reload;
            end else begin
                s_d.cnt = s_q.cnt - RLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{running: 1'b0, cnt: '0, pulse: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign running = s_q.running;
    assign wd_rst  = s_q.pulse;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int MAX_CODE = 6,
    parameter int RLD_W = 12,
    parameter int SYNC_TICKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        wd_rst
);
    localparam int PCODE_W = $clog2(MAX_CODE + 1);

    logic               tick, unlocked, start_req, kick_req, running;
    logic               presc_busy, reload_busy;
    logic [PCODE_W-1:0] prog_code, act_code;
    logic [RLD_W-1:0]   prog_reload, act_reload;

    kwd_regs #(.MAX_CODE(MAX_CODE), .RLD_W(RLD_W), .SYNC_TICKS(SYNC_TICKS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tick(tick), .unlocked(unlocked),
        .start_req(start_req), .kick_req(kick_req),
        .prog_code(prog_code), .act_code(act_code),
        .prog_reload(prog_reload), .act_reload(act_reload),
        .presc_busy(presc_busy), .reload_busy(reload_busy)
    );

    kwd_presc #(.MAX_CODE(MAX_CODE)) u_presc (
        .clk(clk), .rst_n(rst_n), .code(act_code),
        .restart(start_req || (kick_req && running)), .tick(tick)
    );

    kwd_count #(.RLD_W(RLD_W)) u_count (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .kick_req(kick_req),
        .tick(tick), .reload(act_reload), .running(running), .wd_rst(wd_rst)
    );

    always_comb begin
        case (bus_addr)
            A_PRESC:  bus_rdata = BUS_W'(prog_code);
            A_RELOAD: bus_rdata = BUS_W'(prog_reload);
            A_STATUS: bus_rdata = {14'd0, reload_busy, presc_busy};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
    parameter int MAX_CODE = 6,
    parameter int RLD_W = 12,
    localparam int PCODE_W = $clog2(MAX_CODE + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [15:0]        bus_wdata,
    input logic               unlocked,
    input logic [PCODE_W-1:0] prog_code,
    input logic [RLD_W-1:0]   prog_reload,
    input logic               presc_busy,
    input logic               reload_busy,
    input logic               running,
    input logic               wd_rst
);
    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata == 16'h5555) |=> unlocked);

    p_locked_presc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !unlocked) |=> $stable(prog_code));

    p_locked_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !unlocked) |=> $stable(prog_reload));

    p_code_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(prog_code) <= MAX_CODE);

    p_presc_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && unlocked) |=> presc_busy);

    p_reload_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && unlocked) |=> reload_busy);

    p_pulse_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> running);

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> !wd_rst);

    p_never_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
endmodule

bind keyed_wdog kwd_chk #(.MAX_CODE(MAX_CODE), .RLD_W(RLD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .unlocked(unlocked), .prog_code(prog_code),
    .prog_reload(prog_reload), .presc_busy(presc_busy),
    .reload_busy(reload_busy), .running(running), .wd_rst(wd_rst)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
    localparam int MAXC = 8;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        wd_rst;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keyed_wdog #(.MAX_CODE(MAXC), .RLD_W(12), .SYNC_TICKS(SYNC)) u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_rst(wd_rst)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_idle(input int limit, output bit ok);
        int v;
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            rd(2'd3, v);
            if (v == 0) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_pulse(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (wd_rst) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic run_cfg(input int code, input int rl);
        int per, s, p1, p2;
        bit ok;
        per = (rl + 1) * (4 << code);
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(rl));
        wait_idle(20000, ok);
        chk(ok, "R6 R7 flags clear before start", 0, 0);
        wr(2'd0, 16'hCCCC);
        s = cyc;
        wait_pulse(per + 20, p1);
        chk(p1 - s == per, "R4 R8 first pulse delay", p1 - s, per);
        @(negedge clk);
        chk(wd_rst == 1'b0, "R9 pulse width one cycle", wd_rst, 0);
        wait_pulse(per + 20, p2);
        chk(p2 - p1 == per, "R9 repeat period", p2 - p1, per);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, s, s2, p, p2;
        bit ok;
        do_reset();

        // R1: reset state
        chk(wd_rst == 1'b0, "R1 wd_rst low", wd_rst, 0);
        rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 prescaler", v, 0);
        rd(2'd2, v); chk(v == 12'hFFF, "R1 reload", v, 12'hFFF);
        rd(2'd0, v); chk(v == 0, "R2 key reads zero", v, 0);

        // R3: locked after reset
        wr(2'd1, 16'd3);
        rd(2'd1, v); chk(v == 0, "R3 locked prescaler", v, 0);
        rd(2'd3, v); chk(v == 0, "R3 locked status", v, 0);
        wr(2'd2, 16'd5);
        rd(2'd2, v); chk(v == 12'hFFF, "R3 locked reload", v, 12'hFFF);

        // R2, R6: unlock and prescaler write
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd3);
        rd(2'd1, v); chk(v == 3, "R2 prescaler readback", v, 3);
        rd(2'd3, v); chk(v == 1, "R6 prescaler busy set", v, 1);
        repeat (3) @(negedge clk);
        rd(2'd3, v); chk(v == 1, "R6 busy holds for sync ticks", v, 1);
        wait_idle(100, ok);
        chk(ok, "R6 prescaler busy clears", 0, 0);

        // R5, R7: reload write with upper bits
        wr(2'd2, 16'hF123);
        rd(2'd2, v); chk(v == 16'h123, "R5 reload masked", v, 16'h123);
        rd(2'd3, v); chk(v == 2, "R7 reload busy set", v, 2);
        wait_idle(1000, ok);
        chk(ok, "R7 reload busy clears", 0, 0);

        // R3: relock
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd5);
        rd(2'd1, v); chk(v == 3, "R3 relocked prescaler", v, 3);
        wr(2'd2, 16'd7);
        rd(2'd2, v); chk(v == 16'h123, "R3 relocked reload", v, 16'h123);
        rd(2'd3, v); chk(v == 0, "R3 relocked status", v, 0);

        // R4: saturation
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd15);
        rd(2'd1, v); chk(v == MAXC, "R4 code saturates 15", v, MAXC);
        wr(2'd1, 16'd9);
        rd(2'd1, v); chk(v == MAXC, "R4 code saturates 9", v, MAXC);

        // R4, R8, R9: sweep over all codes
        for (int c = 0; c <= MAXC; c++) begin
            run_cfg(c, 0);
            run_cfg(c, 2);
        end
        run_cfg(0, 12'hFFF);
        run_cfg(MAXC, 1);

        // R10: refresh delays the pulse
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd9);
        wait_idle(5000, ok);
        wr(2'd0, 16'hCCCC);
        s = cyc;
        repeat (100) @(negedge clk);
        wr(2'd0, 16'hAAAA);
        s2 = cyc;
        wait_pulse(400, p);
        chk(p - s2 == 160, "R10 pulse after refresh", p - s2, 160);
        chk(p - s != 160, "R10 original deadline skipped", p - s, 0);

        // R11: lock key and other keys do not stop or shift the count
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h1234);
        wait_pulse(400, p2);
        chk(p2 - p == 160, "R11 keeps running", p2 - p, 160);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule